// File: doc/BRIEF.md
# Hashed Duplicate Candidate Table

This block keeps a direct-mapped table that maps block content to the cache location where that content was last seen. Each entry is chosen by an index hash of a block's content and holds a valid flag, a wider content code taken from the same content, and a compact pointer made of a cache set number and a way number. When a block arrives from the lower memory level, the caller presents its index hash and content code. The table answers whether a live candidate with the same code exists and, if it does, where that candidate sits in the cache. The caller then compares the two blocks in full before it treats them as duplicates.

The caller writes an entry when a new block should become the candidate for its hash slot. A write sets the valid flag, the code and the pointer, and replaces whatever the slot held before. The cache reports each eviction with the location that was freed and that block's index hash. The table clears the addressed entry only if the entry still points at the freed location. An entry that has since been repointed to a different block keeps its valid flag. As a result, every valid entry refers to a block that is still resident. Hash generation and the cache array are outside this block.

Top module: `dup_cand_table`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an entry has been written.
- R2: A lookup reports `cand_hit` = 1 only when the lookup was requested, the entry at `lk_index` is valid and its stored code equals `lk_code`.
- R3: On a hit, `cand_ptr` returns the stored pointer, packed as `{set, way}` with the way in the least significant bits. On a miss, `cand_ptr` is all zeros.
- R4: A write with `al_en` = 1 makes the entry at `al_index` valid and stores `al_code` and `al_ptr` in it, replacing any earlier contents.
- R5: An eviction with `ev_en` = 1 clears the valid flag of the entry at `ev_index` when that entry is valid and its stored pointer equals `ev_ptr`.
- R6: An eviction whose `ev_ptr` differs from the stored pointer of the entry at `ev_index` leaves that entry, and every other entry, unchanged.
- R7: When a write and an eviction address the same entry in the same cycle, the write takes effect and the entry ends valid with the written contents.
- R8: With the default registered lookup, `cand_hit` and `cand_ptr` appear on the clock edge that follows the request. They reflect the table as it was before any write or eviction in that same cycle. With `lk_valid` = 0 the next `cand_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | IDX_W | Index hash of the fetched block |
| lk_code | input | CODE_W | Content code of the fetched block |
| al_en | input | 1 | Write (allocate or overwrite) request |
| al_index | input | IDX_W | Entry to write |
| al_code | input | CODE_W | Code to store |
| al_ptr | input | PTR_W | Cache location to store, `{set, way}` |
| ev_en | input | 1 | Eviction notice |
| ev_index | input | IDX_W | Index hash of the evicted block |
| ev_ptr | input | PTR_W | Cache location that was freed |
| cand_hit | output | 1 | A valid candidate with a matching code was found |
| cand_ptr | output | PTR_W | Location of the candidate, zero on a miss |

## Verification
The assertions check four properties on every cycle. A hit never appears without a request one cycle earlier and a code match. Any write leaves its entry valid, and this includes the case where an eviction hits the same entry. A matching eviction clears its entry, and an eviction with a different pointer leaves the entry valid. Other behaviour can only be shown by the bench's scenarios. These are the zero pointer returned on a miss, a lookup that sees the old contents in the cycle its entry is rewritten, the repoint-then-evict sequence, and the absence of side effects on neighbouring entries. For these, a reference model is compared against the outputs across full index sweeps and a long random mix.

// File: rtl/dct_pkg.sv
package dct_pkg;
   // width of a field able to hold n distinct values, never below one bit
   function automatic int field_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   localparam int CODE_W_MIN = 24;
   localparam int CODE_W_MAX = 32;
endpackage

// File: rtl/dct_store.sv
module dct_store #(
   parameter int DEPTH  = 256,
   parameter int CODE_W = 32,
   parameter int PTR_W  = 9,
   localparam int IDX_W = dct_pkg::field_w(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   // write port
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_index,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [PTR_W-1:0]  wr_ptr,
   // invalidate port
   input  logic              clr_en,
   input  logic [IDX_W-1:0]  clr_index,
   // read port A (lookup)
   input  logic [IDX_W-1:0]  ra_index,
   output logic              ra_vld,
   output logic [CODE_W-1:0] ra_code,
   output logic [PTR_W-1:0]  ra_ptr,
   // read port B (eviction check)
   input  logic [IDX_W-1:0]  rb_index,
   output logic              rb_vld,
   output logic [PTR_W-1:0]  rb_ptr
);
   logic [DEPTH-1:0]  vld_q;
   logic [CODE_W-1:0] code_q [DEPTH];
   logic [PTR_W-1:0]  ptr_q  [DEPTH];

   // valid flags: reset, write sets, clear drops; write applied last so it wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (clr_en) vld_q[clr_index] <= 1'b0;
         if (wr_en)  vld_q[wr_index]  <= 1'b1;
      end
   end

   // payload needs no reset: it is only read under a set valid flag
   always_ff @(posedge clk) begin
      if (wr_en) begin
         code_q[wr_index] <= wr_code;
         ptr_q[wr_index]  <= wr_ptr;
      end
   end

   assign ra_vld  = vld_q[ra_index];
   assign ra_code = code_q[ra_index];
   assign ra_ptr  = ptr_q[ra_index];
   assign rb_vld  = vld_q[rb_index];
   assign rb_ptr  = ptr_q[rb_index];

   assert_write_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld_q[$past(wr_index)]);

   assert_write_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clr_en && wr_index == clr_index) |=> vld_q[$past(clr_index)]);
endmodule

// File: rtl/dct_evict_guard.sv
module dct_evict_guard #(
   parameter int PTR_W = 9
) (
   input  logic             ev_en,
   input  logic [PTR_W-1:0] ev_ptr,
   input  logic             ent_vld,
   input  logic [PTR_W-1:0] ent_ptr,
   output logic             clr_en
);
   // drop the entry only if it still refers to the block that left the cache
   always_comb begin
      clr_en = ev_en && ent_vld && (ent_ptr == ev_ptr);
   end
endmodule

// File: rtl/dct_lookup.sv
module dct_lookup #(
   parameter int  CODE_W     = 32,
   parameter int  PTR_W      = 9,
   parameter bit  LOOKUP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [CODE_W-1:0] req_code,
   input  logic              ent_vld,
   input  logic [CODE_W-1:0] ent_code,
   input  logic [PTR_W-1:0]  ent_ptr,
   output logic              hit,
   output logic [PTR_W-1:0]  ptr
);
   logic             hit_c;
   logic [PTR_W-1:0] ptr_c;

   always_comb begin
      hit_c = req && ent_vld && (ent_code == req_code);
      ptr_c = hit_c ? ent_ptr : '0;
   end

   if (LOOKUP_REG) begin : g_reg
      logic             hit_q;
      logic [PTR_W-1:0] ptr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hit_q <= 1'b0;
            ptr_q <= '0;
         end else begin
            hit_q <= hit_c;
            ptr_q <= ptr_c;
         end
      end
      assign hit = hit_q;
      assign ptr = ptr_q;

      assert_hit_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> $past(req));
      assert_hit_needs_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> $past(ent_vld && ent_code == req_code));
   end else begin : g_comb
      assign hit = hit_c;
      assign ptr = ptr_c;

      assert_hit_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
         hit |-> req);
   end
endmodule

// File: rtl/dup_cand_table.sv
module dup_cand_table #(
   parameter int DEPTH      = 256,
   parameter int CODE_W     = 32,
   parameter int SETS       = 256,
   parameter int WAYS       = 2,
   parameter bit LOOKUP_REG = 1'b1,
   localparam int IDX_W = dct_pkg::field_w(DEPTH),
   localparam int SET_W = dct_pkg::field_w(SETS),
   localparam int WAY_W = dct_pkg::field_w(WAYS),
   localparam int PTR_W = SET_W + WAY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [IDX_W-1:0]  lk_index,
   input  logic [CODE_W-1:0] lk_code,
   input  logic              al_en,
   input  logic [IDX_W-1:0]  al_index,
   input  logic [CODE_W-1:0] al_code,
   input  logic [PTR_W-1:0]  al_ptr,
   input  logic              ev_en,
   input  logic [IDX_W-1:0]  ev_index,
   input  logic [PTR_W-1:0]  ev_ptr,
   output logic              cand_hit,
   output logic [PTR_W-1:0]  cand_ptr
);
   // elaboration-time parameter checks
   if (CODE_W < dct_pkg::CODE_W_MIN || CODE_W > dct_pkg::CODE_W_MAX) begin : g_bad_code_w
      $error("dup_cand_table: CODE_W must lie in 24..32");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dup_cand_table: DEPTH must be a power of two of at least 2");
   end
   if (SETS < 1 || WAYS < 1) begin : g_bad_geom
      $error("dup_cand_table: SETS and WAYS must be positive");
   end

   logic              a_vld;
   logic [CODE_W-1:0] a_code;
   logic [PTR_W-1:0]  a_ptr;
   logic              b_vld;
   logic [PTR_W-1:0]  b_ptr;
   logic              clr_en;

   dct_store #(.DEPTH(DEPTH), .CODE_W(CODE_W), .PTR_W(PTR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (al_en),
      .wr_index  (al_index),
      .wr_code   (al_code),
      .wr_ptr    (al_ptr),
      .clr_en    (clr_en),
      .clr_index (ev_index),
      .ra_index  (lk_index),
      .ra_vld    (a_vld),
      .ra_code   (a_code),
      .ra_ptr    (a_ptr),
      .rb_index  (ev_index),
      .rb_vld    (b_vld),
      .rb_ptr    (b_ptr)
   );

   dct_evict_guard #(.PTR_W(PTR_W)) u_guard (
      .ev_en   (ev_en),
      .ev_ptr  (ev_ptr),
      .ent_vld (b_vld),
      .ent_ptr (b_ptr),
      .clr_en  (clr_en)
   );

   dct_lookup #(.CODE_W(CODE_W), .PTR_W(PTR_W), .LOOKUP_REG(LOOKUP_REG)) u_lookup (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (lk_valid),
      .req_code (lk_code),
      .ent_vld  (a_vld),
      .ent_code (a_code),
      .ent_ptr  (a_ptr),
      .hit      (cand_hit),
      .ptr      (cand_ptr)
   );

   // eviction of the location still recorded (no same-slot write) must clear it
   assert_evict_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_en && b_vld && b_ptr == ev_ptr && !(al_en && al_index == ev_index))
      |=> !u_store.vld_q[$past(ev_index)]);

   // eviction of some other location must not drop a live entry
   assert_evict_other_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_en && b_vld && b_ptr != ev_ptr) |=> u_store.vld_q[$past(ev_index)]);
endmodule

// File: tb/dup_cand_table_test.sv
module dup_cand_table_test;
   localparam int DEPTH  = 16;
   localparam int CODE_W = 24;
   localparam int SETS   = 8;
   localparam int WAYS   = 2;
   localparam int IDX_W  = 4;
   localparam int PTR_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              lk_valid = 1'b0;
   logic [IDX_W-1:0]  lk_index = '0;
   logic [CODE_W-1:0] lk_code = '0;
   logic              al_en = 1'b0;
   logic [IDX_W-1:0]  al_index = '0;
   logic [CODE_W-1:0] al_code = '0;
   logic [PTR_W-1:0]  al_ptr = '0;
   logic              ev_en = 1'b0;
   logic [IDX_W-1:0]  ev_index = '0;
   logic [PTR_W-1:0]  ev_ptr = '0;
   logic              cand_hit;
   logic [PTR_W-1:0]  cand_ptr;

   int n_chk = 0;
   int n_bad = 0;

   // reference model of the table
   logic              m_vld  [DEPTH];
   logic [CODE_W-1:0] m_code [DEPTH];
   logic [PTR_W-1:0]  m_ptr  [DEPTH];

   always #4 clk = ~clk; // 125 MHz

   dup_cand_table #(.DEPTH(DEPTH), .CODE_W(CODE_W), .SETS(SETS), .WAYS(WAYS)) uut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_index(lk_index), .lk_code(lk_code),
      .al_en(al_en), .al_index(al_index), .al_code(al_code), .al_ptr(al_ptr),
      .ev_en(ev_en), .ev_index(ev_index), .ev_ptr(ev_ptr),
      .cand_hit(cand_hit), .cand_ptr(cand_ptr)
   );

   function automatic logic [CODE_W-1:0] code_of(input int i);
      return 24'hA50000 ^ (i * 24'h001357);
   endfunction
   function automatic logic [PTR_W-1:0] ptr_of(input int i);
      return PTR_W'((i * 5 + 3) % 16);
   endfunction

   task automatic check(input string req, input logic exp_hit, input logic [PTR_W-1:0] exp_ptr);
      n_chk++;
      if (cand_hit !== exp_hit || cand_ptr !== exp_ptr) begin
         n_bad++;
         $display("FAIL %s: hit/ptr actual %b/%h expected %b/%h", req, cand_hit, cand_ptr,
                  exp_hit, exp_ptr);
      end
   endtask

   // one clock: expected result from the pre-update model, then update model
   task automatic cycle(input string req);
      logic             eh;
      logic [PTR_W-1:0] ep;
      eh = lk_valid && m_vld[lk_index] && (m_code[lk_index] == lk_code);
      ep = eh ? m_ptr[lk_index] : '0;
      if (ev_en && m_vld[ev_index] && m_ptr[ev_index] == ev_ptr) m_vld[ev_index] = 1'b0;
      if (al_en) begin
         m_vld[al_index]  = 1'b1;
         m_code[al_index] = al_code;
         m_ptr[al_index]  = al_ptr;
      end
      @(posedge clk);
      @(negedge clk);
      check(req, eh, ep);
      lk_valid = 1'b0; al_en = 1'b0; ev_en = 1'b0;
   endtask

   task automatic look(input int i, input logic [CODE_W-1:0] c, input string req);
      lk_valid = 1'b1; lk_index = IDX_W'(i); lk_code = c;
      cycle(req);
   endtask

   task automatic alloc(input int i, input logic [CODE_W-1:0] c, input logic [PTR_W-1:0] p);
      al_en = 1'b1; al_index = IDX_W'(i); al_code = c; al_ptr = p;
   endtask

   task automatic evict(input int i, input logic [PTR_W-1:0] p);
      ev_en = 1'b1; ev_index = IDX_W'(i); ev_ptr = p;
   endtask

   initial begin
      #400000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_vld[i] = 1'b0; m_code[i] = '0; m_ptr[i] = '0;
      end
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: fresh table misses everywhere
      for (int i = 0; i < DEPTH; i++) look(i, code_of(i), "R1 lookup after reset");

      // R4: fill every entry
      for (int i = 0; i < DEPTH; i++) begin
         alloc(i, code_of(i), ptr_of(i));
         cycle("R4 write cycle");
      end
      // R2/R3: matching code hits with pointer; altered code misses with zero pointer
      for (int i = 0; i < DEPTH; i++) begin
         look(i, code_of(i), "R2 R3 hit with stored pointer");
         look(i, code_of(i) ^ 24'h000100, "R2 R3 code mismatch miss");
         look(i, code_of(i) ^ 24'h800000, "R2 top code bit mismatch");
      end
      // R8: no request means no hit
      lk_valid = 1'b0; lk_index = 4'd3; lk_code = code_of(3);
      cycle("R8 idle lookup");

      // R8: lookup during rewrite of the same entry sees the old contents
      lk_valid = 1'b1; lk_index = 4'd5; lk_code = code_of(5);
      alloc(5, 24'h123456, 4'hE);
      cycle("R8 old contents during write");
      look(5, 24'h123456, "R4 overwrite visible");
      look(5, code_of(5), "R4 old code gone");

      // R6 then R5: wrong-pointer eviction keeps, right one clears
      for (int i = 0; i < DEPTH; i++) begin
         if (i == 5) continue;
         evict(i, ptr_of(i) ^ 4'h1);
         cycle("R6 wrong pointer evict");
         look(i, code_of(i), "R6 entry kept");
         evict(i, ptr_of(i));
         cycle("R5 matching evict");
         look(i, code_of(i), "R5 entry cleared");
         if (i + 1 < DEPTH && i + 1 != 5)
            look(i + 1, code_of(i + 1), "R6 neighbour untouched");
      end

      // R6: repointed entry survives eviction of its former location
      alloc(7, 24'h0F0F0F, 4'h2); cycle("R4 write A");
      alloc(7, 24'h0F0F0F, 4'h9); cycle("R4 repoint B");
      evict(7, 4'h2); cycle("R6 evict old location");
      look(7, 24'h0F0F0F, "R6 repointed kept");

      // R7: simultaneous write and matching evict on same entry
      evict(7, 4'h9); alloc(7, 24'hBEEF01, 4'h4);
      cycle("R7 collide");
      look(7, 24'hBEEF01, "R7 write wins");
      // R7 plus R5 on different entries in one cycle
      alloc(2, 24'h222222, 4'h6); cycle("R4 setup");
      evict(2, 4'h6); alloc(3, 24'h333333, 4'h1); cycle("R5 R4 parallel");
      look(2, 24'h222222, "R5 parallel clear");
      look(3, 24'h333333, "R4 parallel write");

      // random mix against the model
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom;
         lk_valid = r[0]; lk_index = IDX_W'(r[7:4]);
         lk_code = (r[1]) ? code_of(r[7:4]) : code_of(r[11:8]);
         if (r[2]) alloc(r[11:8], code_of(r[15:12]), PTR_W'(r[19:16]));
         if (r[3]) evict(r[23:20], (r[24]) ? m_ptr[r[23:20]] : PTR_W'(r[28:25]));
         cycle("R2 R5 R6 R7 random mix");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule